// File: doc/BRIEF.md
# Hot-Swap Bus Connect Sequencer

This block sequences when a two-wire bus buffer on a plug-in card may join its card-side bus to a live backplane. It watches two supply-good flags (one per supply domain, with hysteresis handled by the comparators in front of it) and the sampled logic levels of the backplane and card clock and data lines. It holds the buffer in lockout until both supplies are good, runs a fixed initialization delay with line precharge enabled, and then waits for the backplane bus to be quiet before closing the connection.

Quiet means either that all four lines have stayed HIGH for a full idle period, or that all four lines are HIGH and a STOP has just been seen on the backplane pair. Once connected, the rise-time accelerators are enabled and precharge is released, unless the accelerator-control input is LOW, in which case precharge stays on and the accelerators stay off. Loss of either supply sends the block back to lockout from any state. Both delays are parameters counted in clock cycles, and a state code output makes the sequence visible.

Top module: `hsw_connect_seq`

## Requirements
- R1: While `rst_n` is LOW at a clock edge the block enters lockout: `phase` reads 0 and `link_on`, `boost_en` and `precharge_en` are all LOW.
- R2: The block leaves lockout only at the first edge where both `supply_a_ok` and `supply_b_ok` are HIGH, whichever came up first; it then shows `phase` 1 (initialization).
- R3: If either supply flag is LOW at a clock edge, `phase` reads 0 after that edge with all three outputs LOW, from any state and even when a connect condition is met in the same cycle.
- R4: Initialization lasts exactly `INIT_CYCLES` cycles with `precharge_en` HIGH and `link_on` LOW, then `phase` reads 2 (watching).
- R5: In the watching phase the block moves to `phase` 3 after `IDLE_CYCLES` consecutive edges at which all four lines are HIGH.
- R6: Any line LOW at an edge in the watching phase restarts the idle count from zero.
- R7: In the watching phase, if all four lines are HIGH at an edge, backplane data was LOW at the previous edge and backplane clock was HIGH at both edges (a STOP), the block moves to `phase` 3 after that edge.
- R8: In `phase` 3 `link_on` is HIGH; `precharge_en` is LOW when `boost_ctl` is HIGH and HIGH when `boost_ctl` is LOW.
- R9: `boost_en` is HIGH only in `phase` 3 with `boost_ctl` HIGH, and follows `boost_ctl` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_a_ok | input | 1 | Backplane-side supply good |
| supply_b_ok | input | 1 | Card-side supply good |
| bp_data | input | 1 | Sampled backplane data level |
| bp_clock | input | 1 | Sampled backplane clock level |
| card_data | input | 1 | Sampled card data level |
| card_clock | input | 1 | Sampled card clock level |
| boost_ctl | input | 1 | Accelerator control, HIGH allows accelerators |
| link_on | output | 1 | Close the backplane-to-card switches |
| boost_en | output | 1 | Rise-time accelerator enable |
| precharge_en | output | 1 | Line precharge enable |
| phase | output | 2 | State code: 0 lockout, 1 init, 2 watching, 3 connected |

## Verification
Two things can land on one edge: a supply flag dropping and a connect trigger (STOP or idle expiry) in the watching phase; lockout must win. A directed case raises backplane data to form a STOP in the very cycle a supply flag falls and expects `phase` 0 afterwards, and the random phase, with rare supply drops and frequent data toggles, hits the same collision and is judged against a bench reference model every cycle.

// File: rtl/hsw_pkg.sv
// Shared types for the hot-swap connect sequencer.
// Assumes: the state code values are visible on the block's phase output.
package hsw_pkg;
    typedef enum logic [1:0] {
        ST_LOCK  = 2'd0,
        ST_INIT  = 2'd1,
        ST_WATCH = 2'd2,
        ST_LINK  = 2'd3
    } hsw_state_e;
endpackage

// File: rtl/hsw_cycle_timer.sv
// Saturating cycle counter shared by the init and idle delays.
// Assumes: clr has priority over inc; count never wraps.
module hsw_cycle_timer #(
    parameter int MAX_COUNT = 255,
    localparam int CW = $clog2(MAX_COUNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);
    // Count up while inc is held, stop at MAX_COUNT, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (inc && count != CW'(MAX_COUNT))
            count <= count + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(MAX_COUNT)); // R6
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0); // R6
endmodule

// File: rtl/hsw_stop_detect.sv
// Detects a STOP on the backplane pair: data rises while clock stays HIGH.
// Assumes: inputs are already synchronous samples of the line levels.
module hsw_stop_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic bp_data,
    input  logic bp_clock,
    output logic stop_seen
);
    logic data_q;
    logic clock_q;

    // Keep the previous sample of both backplane lines (idle HIGH after reset).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= 1'b1;
            clock_q <= 1'b1;
        end else begin
            data_q  <= bp_data;
            clock_q <= bp_clock;
        end
    end

    // Rising data with clock HIGH on both samples.
    always_comb stop_seen = !data_q && bp_data && clock_q && bp_clock;
endmodule

// File: rtl/hsw_connect_seq.sv
// Top: lockout -> init (precharge) -> watch for idle/STOP -> connected.
// Assumes: supply flags already carry comparator hysteresis; line inputs
// are synchronous samples; INIT_CYCLES and IDLE_CYCLES are at least 1.
module hsw_connect_seq
    import hsw_pkg::*;
#(
    parameter int INIT_CYCLES = 16,
    parameter int IDLE_CYCLES = 12,
    localparam int CNT_MAX = (INIT_CYCLES > IDLE_CYCLES) ? INIT_CYCLES : IDLE_CYCLES,
    localparam int CW = $clog2(CNT_MAX + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_a_ok,
    input  logic       supply_b_ok,
    input  logic       bp_data,
    input  logic       bp_clock,
    input  logic       card_data,
    input  logic       card_clock,
    input  logic       boost_ctl,
    output logic       link_on,
    output logic       boost_en,
    output logic       precharge_en,
    output logic [1:0] phase
);
    hsw_state_e    st, nxt;
    logic          power_ok;
    logic          all_high;
    logic          stop_seen;
    logic          tmr_clr;
    logic          tmr_inc;
    logic [CW-1:0] tmr_cnt;

    hsw_stop_detect u_stop (
        .clk       (clk),
        .rst_n     (rst_n),
        .bp_data   (bp_data),
        .bp_clock  (bp_clock),
        .stop_seen (stop_seen)
    );

    hsw_cycle_timer #(.MAX_COUNT(CNT_MAX)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .count (tmr_cnt)
    );

    // Qualifiers shared by the next-state logic.
    always_comb begin
        power_ok = supply_a_ok && supply_b_ok;
        all_high = bp_data && bp_clock && card_data && card_clock;
    end

    // Next state; supply loss overrides every other condition.
    always_comb begin
        nxt = st;
        if (!power_ok)
            nxt = ST_LOCK;
        else begin
            unique case (st)
                ST_LOCK:  nxt = ST_INIT;
                ST_INIT:  if (tmr_cnt == CW'(INIT_CYCLES - 1)) nxt = ST_WATCH;
                ST_WATCH: if (all_high && (stop_seen || tmr_cnt == CW'(IDLE_CYCLES - 1)))
                              nxt = ST_LINK;
                ST_LINK:  nxt = ST_LINK;
            endcase
        end
    end

    // Timer control: restart on any state change or any LOW while watching.
    always_comb begin
        tmr_clr = (nxt != st) || (st == ST_WATCH && !all_high);
        tmr_inc = (st == ST_INIT) || (st == ST_WATCH);
    end

    // State register with synchronous reset into lockout.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_LOCK;
        else        st <= nxt;
    end

    // Outputs decoded from state, accelerator path gated by boost_ctl.
    always_comb begin
        link_on      = (st == ST_LINK);
        boost_en     = (st == ST_LINK) && boost_ctl;
        precharge_en = (st == ST_INIT) || (st == ST_WATCH) || (st == ST_LINK && !boost_ctl);
        phase        = st;
    end

    AST_LOSS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !(supply_a_ok && supply_b_ok) |=> phase == 2'd0 && !link_on && !boost_en); // R3
    AST_POWER_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0 && supply_a_ok && supply_b_ok) |=> phase == 2'd1); // R2
    AST_LINK_FROM_WATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_on) |-> $past(phase) == 2'd2); // R5
    AST_STOP_LINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && stop_seen && all_high && supply_a_ok && supply_b_ok) |=> link_on); // R7
    AST_BOOST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        boost_en |-> boost_ctl && link_on); // R9
    AST_PRE_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 2'd1 |-> precharge_en && !link_on); // R4
endmodule

// File: tb/hsw_connect_seq_tb.sv
module hsw_connect_seq_tb;
    localparam int EN = 16;
    localparam int ID = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sa = 1'b0, sb = 1'b0;
    logic bd = 1'b1, bc = 1'b1, cd = 1'b1, cc = 1'b1, acc = 1'b1;
    logic link_on, boost_en, precharge_en;
    logic [1:0] phase;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;

    // Reference model state
    int m_st = 0, m_cnt = 0;
    bit m_pd = 1'b1, m_pc = 1'b1;

    always #5 clk = ~clk;

    hsw_connect_seq #(.INIT_CYCLES(EN), .IDLE_CYCLES(ID)) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_a_ok(sa), .supply_b_ok(sb),
        .bp_data(bd), .bp_clock(bc), .card_data(cd), .card_clock(cc),
        .boost_ctl(acc), .link_on(link_on), .boost_en(boost_en),
        .precharge_en(precharge_en), .phase(phase)
    );

    function automatic int next_state(int s, int c, bit pwr, bit hi, bit stop);
        if (!pwr) return 0;
        case (s)
            0: return 1;
            1: return (c == EN - 1) ? 2 : 1;
            2: return (hi && (stop || c == ID - 1)) ? 3 : 2;
            default: return 3;
        endcase
    endfunction

    function automatic bit exp_pre(int s, bit a);
        return (s == 1) || (s == 2) || (s == 3 && !a);
    endfunction

    // Reference model update on each edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pd = 1'b1; m_pc = 1'b1;
        end else begin
            bit hi, stop;
            int n;
            hi = bd && bc && cd && cc;
            stop = !m_pd && bd && m_pc && bc;
            n = next_state(m_st, m_cnt, sa && sb, hi, stop);
            if (n != m_st || (m_st == 2 && !hi)) m_cnt = 0;
            else if (m_st == 1 || m_st == 2) m_cnt = m_cnt + 1;
            m_st = n;
            m_pd = bd; m_pc = bc;
        end
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0d exp=%0d at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    // Continuous comparison against the model, mid-cycle.
    always @(negedge clk) begin
        if (cmp_on) begin
            string t;
            case (m_st)
                0: t = "R2";
                1: t = "R4";
                2: t = "R5";
                default: t = "R8";
            endcase
            chk({t, " phase"}, phase, m_st);
            chk({t, " link"}, link_on, m_st == 3);
            chk("R8 precharge", precharge_en, exp_pre(m_st, acc));
            chk("R9 boost", boost_en, m_st == 3 && acc);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic to_watch();
        for (int k = 0; k < 200 && phase != 2'd2; k++) tick(1);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        tick(3);
        @(negedge clk);
        chk("R1 phase", phase, 0);
        chk("R1 outputs", {link_on, boost_en, precharge_en}, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R2: one supply alone keeps lockout
        tick(1); sb = 1'b1;
        tick(5); @(negedge clk); chk("R2 one supply", phase, 0);
        sa = 1'b1; cd = 1'b0;
        tick(1); @(negedge clk); chk("R2 both supplies", phase, 1);

        // R4: count init cycles
        begin
            int n = 0;
            for (int k = 0; k < 100 && phase == 2'd1; k++) begin
                n++; @(negedge clk);
            end
            chk("R4 init length", n, EN);
            chk("R4 then watch", phase, 2);
        end

        // R6: one LOW restarts the idle count, R5 expiry afterwards
        tick(1); cd = 1'b1;
        tick(ID - 1); cc = 1'b0;
        tick(1); cc = 1'b1;
        tick(ID - 1); @(negedge clk); chk("R6 restart no link", link_on, 0);
        tick(1); @(negedge clk); chk("R5 idle link", link_on, 1);

        // R8: accelerator control while connected
        acc = 1'b0; #1;
        chk("R8 pre low acc", precharge_en, 1);
        chk("R9 boost low acc", boost_en, 0);
        acc = 1'b1; #1;
        chk("R8 pre high acc", precharge_en, 0);
        chk("R9 boost high acc", boost_en, 1);

        // R3: supply loss from connected
        tick(1); sa = 1'b0;
        tick(1); @(negedge clk); chk("R3 loss", phase, 0);
        chk("R3 outputs", {link_on, boost_en, precharge_en}, 0);

        // R7: STOP connects immediately
        sa = 1'b1; bd = 1'b0;
        to_watch(); tick(3);
        bd = 1'b1;
        tick(1); @(negedge clk); chk("R7 stop link", link_on, 1);

        // R3 collision: STOP and supply loss on one edge
        tick(1); sb = 1'b0; tick(1); sb = 1'b1; bd = 1'b0;
        to_watch(); tick(2);
        bd = 1'b1; sb = 1'b0;
        tick(1); @(negedge clk); chk("R3 loss beats stop", phase, 0);
        sb = 1'b1;

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            tick(1);
            sa  = ($urandom % 300) != 0;
            sb  = ($urandom % 300) != 0;
            bc  = ($urandom % 10) != 0;
            if (($urandom % 4) == 0) bd = ~bd;
            cd  = ($urandom % 40) != 0;
            cc  = ($urandom % 40) != 0;
            if (($urandom % 50) == 0) acc = ~acc;
        end
        tick(1);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule